// File: doc/BRIEF.md
# Posted flash write and guarded erase controller

This block sits between a processor's register and data-store interface and an on-chip flash array. It holds a write-unlock key, a program-write-enable bit that sends each data store either to RAM or to flash, and an arm bit for mass erase. It drives a single-cycle command port toward the flash array that carries a byte write or a mass erase.

When a coprocessor is enabled, a flash byte store is not issued at once. It is parked, and a pending flag stays high until the coprocessor's busy level drops. The processor keeps running in the meantime. Further flash stores that arrive while the flag is high are discarded. Mass erase happens only after an arm step followed by a fixed pattern written to the erase register, and only while the debug port is enabled.

Top module: `flash_gate`

## Requirements
- R1: After reset, pend, fl_cmd_valid, pwe and erase_arm are 0 and the stored key is 0.
- R2: A register write with reg_sel=0 loads reg_wdata[3:0] as the key. A flash store is accepted only when the key equals the KEY parameter (default 4'h2). With any other key, no command is issued.
- R3: A store (st_valid) with pwe=0 raises ram_we in the same cycle and issues no flash command. With pwe=1, ram_we stays low.
- R4: When a flash store is accepted, pwe clears in the next cycle. A store that is refused leaves pwe set.
- R5: A register write with reg_sel=1 loads pwe from reg_wdata[0] and erase_arm from reg_wdata[1]. The pwe part of that write is ignored while irq_en=1.
- R6: With cop_en=0, an accepted flash store gives fl_cmd_valid=1 with fl_cmd_op=0 (write) in the next cycle. The command carries the store's address and data and lasts exactly one cycle.
- R7: With cop_en=1, an accepted flash store sets pend in the next cycle. No command is issued while cop_busy stays high.
- R8: When cop_busy is seen low after being high, or cop_en goes low while pend=1, then in the next cycle pend clears and the parked address and data are issued as a one-cycle write command.
- R9: While pend=1, a flash store is dropped. Nothing is queued and pwe stays set.
- R10: With erase_arm=1 and dbg_en=1, writing 8'hAA with reg_sel=2 issues fl_cmd_valid=1 with fl_cmd_op=1 (erase) in the next cycle, and erase_arm clears.
- R11: Writing any value other than 8'hAA with reg_sel=2, or writing with erase_arm=0, issues no erase and leaves erase_arm at 0.
- R12: With dbg_en=0, an erase-register write never erases and it clears erase_arm.
- R13: An erase-register write made while pend=1, or in the same cycle that a flash store is accepted, issues no erase and clears erase_arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 key, 1 control, 2 erase |
| reg_wdata | input | 8 | Register write data |
| st_valid | input | 1 | Data-store strobe |
| st_addr | input | 16 | Store address |
| st_data | input | 8 | Store data |
| irq_en | input | 1 | Interrupts enabled level |
| cop_en | input | 1 | Coprocessor enabled level |
| cop_busy | input | 1 | Coprocessor pass busy level |
| dbg_en | input | 1 | Debug port enabled level |
| ram_we | output | 1 | Store steered to RAM |
| pend | output | 1 | Flash write parked |
| pwe | output | 1 | Program-write-enable bit |
| erase_arm | output | 1 | Mass-erase arm bit |
| fl_cmd_valid | output | 1 | One-cycle flash command strobe |
| fl_cmd_op | output | 1 | 0 write byte, 1 mass erase |
| fl_cmd_addr | output | 16 | Command address |
| fl_cmd_data | output | 8 | Command data |

## Verification
The store path is driven with a correct key and with wrong keys, with the enable bit set and clear, and at extreme addresses. This separates key gating from RAM/flash steering and exposes dropped address or data bits. Posting is tried with busy held high and released by a busy fall, and again released by the coprocessor being switched off. A second store inside the window shows whether requests are dropped rather than queued. Erase is tried with the right and wrong pattern, without arming, with the debug port closed and during a pending write, so that each gate of the sequence is shown to matter on its own.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    SEL_KEY   = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_ERASE = 2'd2
  } fg_sel_e;

  localparam int unsigned CTRL_PWE_BIT = 0;
  localparam int unsigned CTRL_ARM_BIT = 1;
  localparam logic OP_WRITE = 1'b0;
  localparam logic OP_ERASE = 1'b1;
endpackage

// File: rtl/fg_write_post.sv
module fg_write_post #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwe_wr,
  input  logic          pwe_val,
  input  logic          irq_en,
  input  logic          key_ok,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          cop_en,
  input  logic          cop_busy,
  output logic          ram_we,
  output logic          pwe_q,
  output logic          pend_q,
  output logic          path_busy,
  output logic          go_q,
  output logic [AW-1:0] go_addr_q,
  output logic [DW-1:0] go_data_q
);
  logic          busy_q;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;
  logic          flash_req, accept, release_now;
  logic          pwe_d, pend_d, go_d;
  logic [AW-1:0] hold_addr_d, go_addr_d;
  logic [DW-1:0] hold_data_d, go_data_d;

  always_comb begin
    flash_req   = st_valid & pwe_q;
    accept      = flash_req & key_ok & ~pend_q;
    release_now = pend_q & (~cop_en | (busy_q & ~cop_busy));
    ram_we      = st_valid & ~pwe_q;
    path_busy   = pend_q | accept;

    pwe_d = pwe_q;
    if (accept)                 pwe_d = 1'b0;
    else if (pwe_wr && !irq_en) pwe_d = pwe_val;

    pend_d = pend_q;
    if (release_now)           pend_d = 1'b0;
    else if (accept && cop_en) pend_d = 1'b1;

    hold_addr_d = hold_addr_q;
    hold_data_d = hold_data_q;
    if (accept && cop_en) begin
      hold_addr_d = st_addr;
      hold_data_d = st_data;
    end

    go_d      = release_now | (accept & ~cop_en);
    go_addr_d = release_now ? hold_addr_q : st_addr;
    go_data_d = release_now ? hold_data_q : st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwe_q       <= 1'b0;
      pend_q      <= 1'b0;
      busy_q      <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
      go_q        <= 1'b0;
      go_addr_q   <= '0;
      go_data_q   <= '0;
    end else begin
      pwe_q       <= pwe_d;
      pend_q      <= pend_d;
      busy_q      <= cop_busy;
      hold_addr_q <= hold_addr_d;
      hold_data_q <= hold_data_d;
      go_q        <= go_d;
      go_addr_q   <= go_addr_d;
      go_data_q   <= go_data_d;
    end
  end

  p_pwe_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwe_wr && irq_en && !accept) |=> $stable(pwe_q));
  p_pend_needs_cop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cop_en));
  p_drop_while_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && st_valid && pwe_q && !release_now) |=> (pend_q && pwe_q));
  p_pwe_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && pwe_q && key_ok && !pend_q) |=> !pwe_q);
endmodule

// File: rtl/fg_erase_seq.sv
module fg_erase_seq #(
  parameter int unsigned DW        = 8,
  parameter logic [DW-1:0] PATTERN = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          arm_val,
  input  logic          er_wr,
  input  logic [DW-1:0] er_data,
  input  logic          dbg_en,
  input  logic          blocked,
  output logic          arm_q,
  output logic          er_go_q
);
  logic arm_d, go_d;

  always_comb begin
    go_d  = er_wr & arm_q & (er_data == PATTERN) & dbg_en & ~blocked;
    arm_d = arm_q;
    if (er_wr)       arm_d = 1'b0;
    else if (ctl_wr) arm_d = arm_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      er_go_q <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      er_go_q <= go_d;
    end
  end

  p_erase_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    er_go_q |-> ($past(dbg_en) && $past(arm_q) && $past(er_data) == PATTERN));
  p_arm_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    er_wr |=> !arm_q);
  p_erase_blocked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (er_wr && blocked) |=> !er_go_q);
endmodule

// File: rtl/flash_gate.sv
module flash_gate
  import fg_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned KW          = 4,
  parameter logic [KW-1:0] KEY       = 4'h2,
  parameter logic [DW-1:0] ERASE_PAT = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          irq_en,
  input  logic          cop_en,
  input  logic          cop_busy,
  input  logic          dbg_en,
  output logic          ram_we,
  output logic          pend,
  output logic          pwe,
  output logic          erase_arm,
  output logic          fl_cmd_valid,
  output logic          fl_cmd_op,
  output logic [AW-1:0] fl_cmd_addr,
  output logic [DW-1:0] fl_cmd_data
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_i_n;
  logic [KW-1:0]          key_q, key_d;
  logic                   key_ok, key_wr, ctl_wr, er_wr;
  logic                   path_busy, wr_go, er_go;
  logic [AW-1:0]          wr_addr;
  logic [DW-1:0]          wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    key_wr = reg_wr & (reg_sel == SEL_KEY);
    ctl_wr = reg_wr & (reg_sel == SEL_CTRL);
    er_wr  = reg_wr & (reg_sel == SEL_ERASE);
    key_d  = key_wr ? reg_wdata[KW-1:0] : key_q;
    key_ok = (key_q == KEY);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) key_q <= '0;
    else          key_q <= key_d;
  end

  fg_write_post #(.AW(AW), .DW(DW)) u_post (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pwe_wr    (ctl_wr),
    .pwe_val   (reg_wdata[CTRL_PWE_BIT]),
    .irq_en    (irq_en),
    .key_ok    (key_ok),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .cop_en    (cop_en),
    .cop_busy  (cop_busy),
    .ram_we    (ram_we),
    .pwe_q     (pwe),
    .pend_q    (pend),
    .path_busy (path_busy),
    .go_q      (wr_go),
    .go_addr_q (wr_addr),
    .go_data_q (wr_data)
  );

  fg_erase_seq #(.DW(DW), .PATTERN(ERASE_PAT)) u_erase (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ctl_wr  (ctl_wr),
    .arm_val (reg_wdata[CTRL_ARM_BIT]),
    .er_wr   (er_wr),
    .er_data (reg_wdata),
    .dbg_en  (dbg_en),
    .blocked (path_busy),
    .arm_q   (erase_arm),
    .er_go_q (er_go)
  );

  always_comb begin
    fl_cmd_valid = wr_go | er_go;
    fl_cmd_op    = er_go ? OP_ERASE : OP_WRITE;
    fl_cmd_addr  = er_go ? '0 : wr_addr;
    fl_cmd_data  = er_go ? '0 : wr_data;
  end

  p_port_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(wr_go && er_go));
  p_write_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fl_cmd_valid && fl_cmd_op == OP_WRITE && !$past(pend)) |-> $past(key_ok));
  p_release_strobe_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(pend) |-> (fl_cmd_valid && fl_cmd_op == OP_WRITE));
  p_ram_path_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_valid && !pwe) |-> ram_we);
endmodule

// File: tb/flash_gate_test.sv
module flash_gate_test;
  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic        st_valid;
  logic [15:0] st_addr;
  logic [7:0]  st_data;
  logic        irq_en, cop_en, cop_busy, dbg_en;
  logic        ram_we, pend, pwe, erase_arm;
  logic        fl_cmd_valid, fl_cmd_op;
  logic [15:0] fl_cmd_addr;
  logic [7:0]  fl_cmd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic ram_seen;

  flash_gate uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .irq_en(irq_en), .cop_en(cop_en),
    .cop_busy(cop_busy), .dbg_en(dbg_en), .ram_we(ram_we), .pend(pend),
    .pwe(pwe), .erase_arm(erase_arm), .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd_op(fl_cmd_op), .fl_cmd_addr(fl_cmd_addr),
    .fl_cmd_data(fl_cmd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // fields: key[30:27] pwe[26] addr[25:10] data[9:2] cmd[1] ram[0]
  localparam logic [30:0] VEC [6] = '{
    {4'h2, 1'b1, 16'h1234, 8'h5A, 1'b1, 1'b0},
    {4'h3, 1'b1, 16'h0001, 8'h11, 1'b0, 1'b0},
    {4'h2, 1'b0, 16'h0100, 8'h22, 1'b0, 1'b1},
    {4'h0, 1'b0, 16'h8000, 8'h33, 1'b0, 1'b1},
    {4'h2, 1'b1, 16'hFFFF, 8'h00, 1'b1, 1'b0},
    {4'hF, 1'b1, 16'h0F0F, 8'hC3, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic store(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1 ram_seen = ram_we;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0; st_valid = 0;
    st_addr = 0; st_data = 0; irq_en = 0; cop_en = 0; cop_busy = 0; dbg_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!pend && !fl_cmd_valid && !pwe && !erase_arm, "R1 reset",
        {pend, fl_cmd_valid, pwe, erase_arm}, 0);

    // table walk: R2 R3 R4 R6 with coprocessor disabled
    foreach (VEC[i]) begin
      reg_write(2'd0, {4'h0, VEC[i][30:27]});
      reg_write(2'd1, {7'd0, VEC[i][26]});
      store(VEC[i][25:10], VEC[i][9:2]);
      chk(fl_cmd_valid == VEC[i][1], "R2/R6 cmd valid", fl_cmd_valid, VEC[i][1]);
      chk(ram_seen == VEC[i][0], "R3 ram steer", ram_seen, VEC[i][0]);
      if (VEC[i][1]) begin
        chk(fl_cmd_op == 1'b0 && fl_cmd_addr == VEC[i][25:10] && fl_cmd_data == VEC[i][9:2],
            "R6 cmd payload", {fl_cmd_addr, fl_cmd_data}, {VEC[i][25:10], VEC[i][9:2]});
        chk(!pwe, "R4 pwe cleared", pwe, 0);
        @(negedge clk);
        chk(!fl_cmd_valid, "R6 one cycle", fl_cmd_valid, 0);
      end else if (VEC[i][26]) begin
        chk(pwe, "R4 pwe kept on refusal", pwe, 1);
      end
    end

    // R5 interrupt lock
    reg_write(2'd0, 8'h02);
    reg_write(2'd1, 8'h00);
    irq_en = 1'b1;
    reg_write(2'd1, 8'h01);
    chk(!pwe, "R5 locked", pwe, 0);
    irq_en = 1'b0;
    reg_write(2'd1, 8'h01);
    chk(pwe, "R5 unlocked", pwe, 1);

    // R7 R8 R9 posting
    cop_en = 1'b1; cop_busy = 1'b1;
    store(16'hA5A5, 8'h77);
    chk(pend && !fl_cmd_valid, "R7 posted", {pend, fl_cmd_valid}, 2);
    repeat (3) begin
      @(negedge clk);
      chk(pend && !fl_cmd_valid, "R7 held", {pend, fl_cmd_valid}, 2);
    end
    reg_write(2'd1, 8'h01);
    store(16'h0042, 8'h99);
    chk(pend && !fl_cmd_valid && pwe, "R9 dropped", {pend, fl_cmd_valid, pwe}, 5);
    @(negedge clk);
    cop_busy = 1'b0;
    @(negedge clk);
    chk(!pend && fl_cmd_valid && !fl_cmd_op && fl_cmd_addr == 16'hA5A5 && fl_cmd_data == 8'h77,
        "R8 release on busy fall", {fl_cmd_addr, fl_cmd_data}, {16'hA5A5, 8'h77});
    @(negedge clk);
    chk(!fl_cmd_valid, "R8 one cycle", fl_cmd_valid, 0);
    store(16'h0042, 8'h99);
    chk(pend && !fl_cmd_valid, "R7 posted idle busy", {pend, fl_cmd_valid}, 2);
    cop_en = 1'b0;
    @(negedge clk);
    chk(!pend && fl_cmd_valid && fl_cmd_addr == 16'h0042 && fl_cmd_data == 8'h99,
        "R8 release on cop off", {fl_cmd_addr, fl_cmd_data}, {16'h0042, 8'h99});

    // R10 erase
    dbg_en = 1'b1;
    reg_write(2'd1, 8'h02);
    chk(erase_arm, "R10 armed", erase_arm, 1);
    reg_write(2'd2, 8'hAA);
    chk(fl_cmd_valid && fl_cmd_op && !erase_arm, "R10 erase",
        {fl_cmd_valid, fl_cmd_op, erase_arm}, 6);

    // R11 wrong pattern, then no arm
    reg_write(2'd1, 8'h02);
    reg_write(2'd2, 8'h55);
    chk(!fl_cmd_valid && !erase_arm, "R11 bad pattern", {fl_cmd_valid, erase_arm}, 0);
    reg_write(2'd2, 8'hAA);
    chk(!fl_cmd_valid, "R11 unarmed", fl_cmd_valid, 0);

    // R12 debug closed
    dbg_en = 1'b0;
    reg_write(2'd1, 8'h02);
    reg_write(2'd2, 8'hAA);
    chk(!fl_cmd_valid && !erase_arm, "R12 debug off", {fl_cmd_valid, erase_arm}, 0);

    // R13 erase during pending write
    dbg_en = 1'b1; cop_en = 1'b1; cop_busy = 1'b1;
    reg_write(2'd1, 8'h01);
    store(16'h0200, 8'h5C);
    reg_write(2'd1, 8'h02);
    reg_write(2'd2, 8'hAA);
    chk(pend && !fl_cmd_valid && !erase_arm, "R13 blocked", {pend, fl_cmd_valid, erase_arm}, 4);
    cop_busy = 1'b0;
    @(negedge clk);
    chk(fl_cmd_valid && !fl_cmd_op && fl_cmd_addr == 16'h0200, "R13 write still issued",
        fl_cmd_addr, 16'h0200);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule